// File: doc/BRIEF.md
# Random allocation tag generator

This block picks a 4-bit memory allocation tag. A request supplies a start tag, a 16-bit seed, a 16-bit exclusion mask and a tag offset. There are two modes. In random mode, the seed is stepped four times through a 16-bit linear feedback shift register, and the four feedback bits form the offset. In fixed mode, the offset is taken directly from the request and the seed is left alone. The generator then walks a ring of sixteen tags, moving up from the start tag and passing over every tag whose mask bit is set. It inspects one candidate per clock.

The caller holds the random state, which is a seed and a start tag. It feeds that state back on the next request using the updated seed and start values the block returns. A seed of zero is not replaced: the caller must provide a nonzero seed if it wants varied tags.

The controller is a four-state machine:
- `ST_IDLE` waits for a request. Its transitions are: accept to `ST_FIN` when the mask is all ones, accept to `ST_SETTLE` when the effective offset is zero, and accept to `ST_HOP` otherwise.
- `ST_SETTLE` moves past excluded tags starting at the start tag. It moves to `ST_FIN` once the current tag is allowed.
- `ST_HOP` steps to the next tag on every cycle. It counts a step each time it lands on an allowed tag, and moves to `ST_FIN` when the last step lands.
- `ST_FIN` pulses done and returns to `ST_IDLE`.

Top module: `tagpick_top`

## Requirements
- R1: After reset, `done_o` and `busy_o` are 0, and `tag_o`, `seed_o` and `start_o` are all 0.
- R2: One register step computes f = s[5]^s[3]^s[2]^s[0], then sets s = {f, s[15:1]}. After a random-mode request (`mode_i`=0), `seed_o` equals the seed after four such steps.
- R3: In random mode, the feedback bit of step i (i = 0..3) is bit i of the offset used for the walk.
- R4: If `excl_i` is 16'hFFFF, the result tag is 0, and `done_o` rises on the first cycle after the request is accepted.
- R5: With an effective offset of 0, the result is the first tag at or above the start tag whose bit in `excl_i` is 0, wrapping from 15 to 0.
- R6: With an effective offset n > 0, the walk makes n steps. Each step advances by one modulo 16 and passes over tags whose `excl_i` bit is set.
- R7: After a random-mode request, `start_o` equals `tag_o`.
- R8: In fixed mode (`mode_i`=1), the offset is `offset_i`, `seed_o` equals the request's seed unchanged, and `start_o` equals the request's start tag.
- R9: The walk examines exactly one candidate tag per cycle. The number of clock edges from acceptance to `done_o` is 1 for an all-ones mask. For offset 0 it is 2 plus the number of excluded tags passed over. Otherwise it is 1 plus the number of candidates visited. `busy_o` is high from the cycle after acceptance through the `done_o` cycle, and `done_o` lasts one cycle.
- R10: A request raised while `busy_o` is high is ignored, and the running result is unaffected.
- R11: A zero seed in random mode produces offset 0 and returns `seed_o` = 0.
- R12: `tag_o`, `seed_o` and `start_o` hold their values after `done_o` until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, accepted while idle |
| mode_i | input | 1 | 0 = random, 1 = fixed offset |
| start_i | input | 4 | Start tag |
| seed_i | input | 16 | Seed for the shift register |
| excl_i | input | 16 | Exclusion mask, bit t set excludes tag t |
| offset_i | input | 4 | Tag offset used in fixed mode |
| tag_o | output | 4 | Chosen tag |
| seed_o | output | 16 | Updated seed |
| start_o | output | 4 | Updated start state |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while a request is in progress |

## Verification
A wrong internal state shows up at the ports as soon as the request completes. If the captured seed or offset is corrupted, `seed_o` and `tag_o` are wrong at `done_o`. If a step is miscounted in the walk, a different tag appears. If a candidate is examined twice, or one is skipped, `done_o` arrives on a different cycle from the one the bench predicts exactly for each request. If the machine stays in a state too long, `busy_o` is still high past the predicted edge, or the result registers change after `done_o` while they should hold.

// File: rtl/tagpick_pkg.sv
package tagpick_pkg;

    typedef enum logic {
        MODE_RAND  = 1'b0,
        MODE_FIXED = 1'b1
    } tp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HOP    = 2'd2,
        ST_FIN    = 2'd3
    } tp_state_e;

endpackage

// File: rtl/tagpick_lfsr.sv
// Unrolled multi-step shift register: one feedback bit per step,
// gathered least significant first into the offset.
module tagpick_lfsr #(
    parameter int          SEED_W   = 16,
    parameter int          STEPS    = 4,
    parameter logic [15:0] TAP_MASK = 16'h002D
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [STEPS-1:0]  offset_o,
    output logic [SEED_W-1:0] seed_o
);
    logic [SEED_W-1:0] chain [STEPS+1];

    assign chain[0] = seed_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        logic fb;
        assign fb            = ^(chain[g] & SEED_W'(TAP_MASK));
        assign chain[g+1]    = {fb, chain[g][SEED_W-1:1]};
        assign offset_o[g]   = fb;
    end

    assign seed_o = chain[STEPS];

endmodule

// File: rtl/tagpick_ring.sv
// Ring neighbour and exclusion lookup for the current candidate.
module tagpick_ring #(
    parameter int TAG_W = 4,
    localparam int NTAGS = 1 << TAG_W
) (
    input  logic [TAG_W-1:0] cur_i,
    input  logic [NTAGS-1:0] excl_i,
    output logic [TAG_W-1:0] nxt_o,
    output logic             cur_blk_o,
    output logic             nxt_blk_o
);
    assign nxt_o     = cur_i + TAG_W'(1);
    assign cur_blk_o = excl_i[cur_i];
    assign nxt_blk_o = excl_i[nxt_o];
endmodule

// File: rtl/tagpick_fsm.sv
module tagpick_fsm
    import tagpick_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int SEED_W = 16,
    localparam int NTAGS = 1 << TAG_W,
    localparam int CNT_W = TAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              mode_i,
    input  logic [TAG_W-1:0]  start_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic [NTAGS-1:0]  excl_i,
    input  logic [TAG_W-1:0]  offset_i,
    input  logic [TAG_W-1:0]  rnd_off_i,
    input  logic [SEED_W-1:0] rnd_seed_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic [SEED_W-1:0] seed_o,
    output logic [TAG_W-1:0]  start_o,
    output logic              done_o,
    output logic              busy_o
);
    tp_state_e         state_q, state_d;
    tp_mode_e          mode_q;
    logic [TAG_W-1:0]  cur_q;
    logic [TAG_W-1:0]  rem_q;
    logic [TAG_W-1:0]  start_q;
    logic [SEED_W-1:0] seed_q;
    logic [NTAGS-1:0]  excl_q;
    logic [CNT_W-1:0]  step_cnt_q;

    logic [TAG_W-1:0]  nxt;
    logic              cur_blk;
    logic              nxt_blk;
    logic [TAG_W-1:0]  eff_off;
    logic              accept;

    tagpick_ring #(.TAG_W(TAG_W)) ring_i (
        .cur_i     (cur_q),
        .excl_i    (excl_q),
        .nxt_o     (nxt),
        .cur_blk_o (cur_blk),
        .nxt_blk_o (nxt_blk)
    );

    assign accept  = (state_q == ST_IDLE) && req_i;
    assign eff_off = (tp_mode_e'(mode_i) == MODE_RAND) ? rnd_off_i : offset_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    if (&excl_i)               state_d = ST_FIN;
                    else if (eff_off == '0)    state_d = ST_SETTLE;
                    else                       state_d = ST_HOP;
                end
            end
            ST_SETTLE: begin
                if (!cur_blk) state_d = ST_FIN;
            end
            ST_HOP: begin
                if (!nxt_blk && rem_q == TAG_W'(1)) state_d = ST_FIN;
            end
            ST_FIN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_RAND;
            cur_q      <= '0;
            rem_q      <= '0;
            start_q    <= '0;
            seed_q     <= '0;
            excl_q     <= '0;
            step_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q     <= tp_mode_e'(mode_i);
                        cur_q      <= (&excl_i) ? '0 : start_i;
                        rem_q      <= eff_off;
                        start_q    <= start_i;
                        seed_q     <= (tp_mode_e'(mode_i) == MODE_RAND) ? rnd_seed_i : seed_i;
                        excl_q     <= excl_i;
                        step_cnt_q <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (cur_blk) begin
                        cur_q      <= nxt;
                        step_cnt_q <= step_cnt_q + CNT_W'(1);
                    end else begin
                        step_cnt_q <= '0;
                    end
                end
                ST_HOP: begin
                    cur_q <= nxt;
                    if (nxt_blk) begin
                        step_cnt_q <= step_cnt_q + CNT_W'(1);
                    end else begin
                        step_cnt_q <= '0;
                        rem_q      <= rem_q - TAG_W'(1);
                    end
                end
                ST_FIN: step_cnt_q <= '0;
                default: step_cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        tag_o   = cur_q;
        seed_o  = seed_q;
        start_o = (mode_q == MODE_RAND) ? cur_q : start_q;
        done_o  = (state_q == ST_FIN);
        busy_o  = (state_q != ST_IDLE);
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: one step never visits more than the ring size of candidates
    a_r9_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step_cnt_q < CNT_W'(NTAGS));

    // R10: captured request state is frozen while busy
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(seed_q) && $stable(excl_q) && $stable(mode_q) && $stable(start_q)));

    // R5 / R6: a finished walk never lands on an excluded tag
    a_r5_tag_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(&excl_q)) |-> !excl_q[tag_o]);

    // R4: fully excluded ring yields tag zero
    a_r4_all_excl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (&excl_q)) |-> (tag_o == '0));

    // R12: the result does not move while idle
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req_i) |=> ($stable(tag_o) && $stable(seed_o) && $stable(start_o)));

endmodule

// File: rtl/tagpick_top.sv
module tagpick_top
    import tagpick_pkg::*;
#(
    parameter int          TAG_W    = 4,
    parameter int          SEED_W   = 16,
    parameter logic [15:0] TAP_MASK = 16'h002D,
    localparam int         NTAGS    = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              mode_i,
    input  logic [TAG_W-1:0]  start_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic [NTAGS-1:0]  excl_i,
    input  logic [TAG_W-1:0]  offset_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic [SEED_W-1:0] seed_o,
    output logic [TAG_W-1:0]  start_o,
    output logic              done_o,
    output logic              busy_o
);
    logic [TAG_W-1:0]  rnd_off;
    logic [SEED_W-1:0] rnd_seed;

    tagpick_lfsr #(
        .SEED_W   (SEED_W),
        .STEPS    (TAG_W),
        .TAP_MASK (TAP_MASK)
    ) lfsr_i (
        .seed_i   (seed_i),
        .offset_o (rnd_off),
        .seed_o   (rnd_seed)
    );

    tagpick_fsm #(
        .TAG_W  (TAG_W),
        .SEED_W (SEED_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .mode_i     (mode_i),
        .start_i    (start_i),
        .seed_i     (seed_i),
        .excl_i     (excl_i),
        .offset_i   (offset_i),
        .rnd_off_i  (rnd_off),
        .rnd_seed_i (rnd_seed),
        .tag_o      (tag_o),
        .seed_o     (seed_o),
        .start_o    (start_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

endmodule

// File: tb/tagpick_top_tb_top.sv
`timescale 1ns/1ps
module tagpick_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [3:0]  start_i = '0;
    logic [15:0] seed_i = '0;
    logic [15:0] excl_i = '0;
    logic [3:0]  offset_i = '0;
    logic [3:0]  tag_o;
    logic [15:0] seed_o;
    logic [3:0]  start_o;
    logic        done_o;
    logic        busy_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tagpick_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .start_i(start_i), .seed_i(seed_i), .excl_i(excl_i), .offset_i(offset_i),
        .tag_o(tag_o), .seed_o(seed_o), .start_o(start_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    // {mode, start, seed, excl, offset}
    localparam logic [40:0] VEC [12] = '{
        {1'b0, 4'h3, 16'hACE1, 16'h0001, 4'h0},
        {1'b0, 4'h0, 16'h1234, 16'h0000, 4'h0},
        {1'b0, 4'hF, 16'hBEEF, 16'h8001, 4'h0},
        {1'b1, 4'h5, 16'h1111, 16'h0000, 4'h3},
        {1'b1, 4'hE, 16'h2222, 16'h0000, 4'h4},
        {1'b1, 4'h2, 16'h3333, 16'h00F0, 4'h2},
        {1'b1, 4'h7, 16'h4444, 16'h0080, 4'h0},
        {1'b1, 4'hF, 16'h5555, 16'h8001, 4'h0},
        {1'b1, 4'h4, 16'h6666, 16'hFFFF, 4'h5},
        {1'b0, 4'h9, 16'h0000, 16'h0000, 4'h7},
        {1'b1, 4'h0, 16'h7777, 16'h7FFF, 4'hF},
        {1'b0, 4'h6, 16'h5A5A, 16'hFFFE, 4'h0}
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic model(input logic md, input logic [3:0] st, input logic [15:0] sd,
                         input logic [15:0] ex, input logic [3:0] of,
                         output logic [3:0] tg, output logic [15:0] so,
                         output logic [3:0] sto, output int edges);
        logic [15:0] s = sd;
        logic [3:0]  off = of;
        logic [3:0]  t = st;
        if (!md) begin
            for (int i = 0; i < 4; i++) begin
                logic fb;
                fb = s[5] ^ s[3] ^ s[2] ^ s[0];
                s = {fb, s[15:1]};
                off[i] = fb;
            end
        end
        if (ex == 16'hFFFF) begin
            t = 4'h0; edges = 1;
        end else if (off == 4'h0) begin
            edges = 2;
            while (ex[t]) begin t = t + 4'h1; edges++; end
        end else begin
            edges = 1;
            for (int k = 0; k < off; k++) begin
                t = t + 4'h1; edges++;
                while (ex[t]) begin t = t + 4'h1; edges++; end
            end
        end
        tg = t;
        so = md ? sd : s;
        sto = md ? st : t;
    endtask

    task automatic launch(input logic [40:0] v);
        @(negedge clk);
        mode_i = v[40]; start_i = v[39:36]; seed_i = v[35:20];
        excl_i = v[19:4]; offset_i = v[3:0]; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic wait_done(output int edges, output int busy_gaps);
        edges = 1; busy_gaps = 0;
        while (!done_o && edges < 400) begin
            if (!busy_o) busy_gaps++;
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic run_vec(input logic [40:0] v, input string rq);
        logic [3:0] etag, est; logic [15:0] esd; int eedg, edg, gaps;
        model(v[40], v[39:36], v[35:20], v[19:4], v[3:0], etag, esd, est, eedg);
        launch(v);
        wait_done(edg, gaps);
        check({rq, " tag"}, 32'(tag_o), 32'(etag));
        check(v[40] ? "R8 seed" : "R2 seed", 32'(seed_o), 32'(esd));
        check(v[40] ? "R8 start" : "R7 start", 32'(start_o), 32'(est));
        check("R9 latency", edg, eedg);
        check("R9 busy", gaps, 0);
        @(negedge clk);
        check("R9 done pulse", 32'(done_o), 0);
        check("R9 busy drop", 32'(busy_o), 0);
        repeat (2) @(negedge clk);
        check("R12 hold tag", 32'(tag_o), 32'(etag));
        check("R12 hold seed", 32'(seed_o), 32'(esd));
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 done", 32'(done_o), 0);
        check("R1 busy", 32'(busy_o), 0);
        check("R1 tag", 32'(tag_o), 0);
        check("R1 seed", 32'(seed_o), 0);
        check("R1 start", 32'(start_o), 0);

        for (int i = 0; i < 12; i++) begin
            string rq;
            if (VEC[i][19:4] == 16'hFFFF)       rq = "R4";
            else if (VEC[i][35:20] == 16'h0 && !VEC[i][40]) rq = "R11";
            else if (!VEC[i][40])               rq = "R3";
            else if (VEC[i][3:0] == 4'h0)       rq = "R5";
            else                                rq = "R6";
            run_vec(VEC[i], rq);
        end

        // R11: zero seed passes through, offset zero selects start tag
        run_vec({1'b0, 4'hC, 16'h0000, 16'h0000, 4'h0}, "R11");
        check("R11 seed zero", 32'(seed_o), 0);
        check("R11 tag is start", 32'(tag_o), 32'hC);

        // R10: request while busy is ignored
        begin
            logic [3:0] etag, est; logic [15:0] esd; int eedg, edg, gaps;
            model(1'b1, 4'h0, 16'h7777, 16'h7FFF, 4'hF, etag, esd, est, eedg);
            launch({1'b1, 4'h0, 16'h7777, 16'h7FFF, 4'hF});
            repeat (3) @(negedge clk);
            mode_i = 1'b0; start_i = 4'h3; seed_i = 16'hFFFF; excl_i = 16'h0; req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
            wait_done(edg, gaps);
            check("R10 latency", edg + 4, eedg);
            check("R10 tag", 32'(tag_o), 32'(etag));
            check("R10 seed", 32'(seed_o), 32'(esd));
            check("R10 start", 32'(start_o), 32'(est));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule